// File: doc/BRIEF.md
# Completion Stall Attribution Counter

This block charges the cycles in which instruction-group completion is held up to one reason, separately for each of two hardware threads. Each cycle, every thread presents a stalled flag, a vector of candidate cause flags and a group-done strobe. Stalled cycles are not charged one at a time. They build up in a per-thread pending accumulator, and the whole amount goes to a single cause counter when the group completes.

The cause charged is the most recent one observed while the thread was stalled. When several cause flags are raised in one stalled cycle, a fixed priority picks one of them, and a data-cache miss outranks every functional-unit cause. A flush throws away the pending cycles. Software reads a counter by giving a thread index and a cause index, and the value appears one cycle later. A synchronous clear zeroes every counter and every accumulator.

Top module: `stall_attrib_ctr`

## Requirements
- R1: After reset every counter holds zero and `rd_data` is zero.
- R2: Each cycle in which `grp_stall[t]` is high and `grp_done[t]` is low adds one to thread t's pending count. When `grp_done[t]` is high, the whole pending count is added in one step to the counter of the chosen cause. A read issued in the following cycle returns the new value.
- R3: The chosen cause is the code picked in the latest stalled cycle that had any cause flag set. Stalled cycles with no cause flag still count, and they keep the earlier cause.
- R4: Cause flag bit i of a thread's six-bit group in `stall_why` (thread t uses bits 6t..6t+5) stands for cause code i. The codes are 0 cache miss, 1 divide/square-root, 2 integer divide, 3 other floating-point, 4 fixed-point, 5 empty pipe after branch mispredict. When several flags are set in the same stalled cycle, the lowest code wins.
- R5: The two threads have separate pending counts, causes and counters. One thread's activity never changes the other thread's counters.
- R6: `grp_flush[t]` discards thread t's pending count and cause without changing any counter. This also applies when the flush arrives in the same cycle as `grp_done[t]`.
- R7: A completion charges nothing when the pending count is zero, or when no cause flag was seen since the last completion, flush or clear. The pending count is dropped in both cases.
- R8: The stall and cause flags present in a completion cycle are ignored. Accumulation starts again in the next cycle.
- R9: `rd_data` shows, one cycle after the request, the counter selected by `rd_tid` and `rd_sel`, as it stood before any charge made in the request cycle. A `rd_sel` of 6 or above returns zero.
- R10: `clear` zeroes all counters and all pending state. It takes precedence over a completion in the same cycle.
- R11: Counters and pending counts saturate at all ones instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous zeroing of all counters and pending state |
| grp_stall | input | NUM_THR | Completion stalled this cycle, one bit per thread |
| stall_why | input | NUM_THR*6 | Candidate cause flags, six per thread |
| grp_done | input | NUM_THR | Group completes this cycle, one bit per thread |
| grp_flush | input | NUM_THR | Thread flushed, pending cycles discarded |
| rd_tid | input | TID_W | Thread index for a read |
| rd_sel | input | SEL_W | Cause index for a read |
| rd_data | output | CNT_W | Selected counter value, one cycle after the request |

## Verification
A read can land in the same cycle as a completion that charges the counter being read. The bench provokes this by arming a read of thread 1's branch-mispredict counter in the very cycle that thread's group completes. It expects the old value, and the value including the charge on the read that follows. The same collision is also checked between a completion and `clear`, where the clear must win and leave zero behind.

// File: rtl/stall_attrib_pkg.sv
package stall_attrib_pkg;

    localparam int CAUSE_N = 6;

    // cause codes; a lower code wins when flags coincide
    typedef enum logic [2:0] {
        CZ_MISS    = 3'd0,
        CZ_DSQRT   = 3'd1,
        CZ_IDIV    = 3'd2,
        CZ_FPOP    = 3'd3,
        CZ_FXOP    = 3'd4,
        CZ_BRFLUSH = 3'd5
    } cause_e;

endpackage

// File: rtl/stall_cause_pick.sv
module stall_cause_pick #(
    parameter int NC = 6,
    parameter int CW = 3
) (
    input  logic [NC-1:0] why,
    output logic          any,
    output logic [CW-1:0] code
);

    always_comb begin
        any  = |why;
        code = '0;
        for (int i = NC - 1; i >= 0; i--) begin
            if (why[i]) begin
                code = CW'(i);
            end
        end
    end

endmodule

// File: rtl/stall_thread_track.sv
module stall_thread_track #(
    parameter int NC = 6,
    parameter int CW = 3,
    parameter int PW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          stall,
    input  logic [NC-1:0] why,
    input  logic          done,
    input  logic          flush,
    output logic          chg_vld,
    output logic [CW-1:0] chg_code,
    output logic [PW-1:0] chg_amt
);

    typedef struct packed {
        logic [PW-1:0] pend;
        logic          seen;
        logic [CW-1:0] code;
    } trk_t;

    trk_t trk_d, trk_q;

    logic          pick_any;
    logic [CW-1:0] pick_code;

    stall_cause_pick #(.NC(NC), .CW(CW)) u_pick (
        .why  (why),
        .any  (pick_any),
        .code (pick_code)
    );

    always_comb begin
        trk_d    = trk_q;
        chg_vld  = done && !flush && !clear && trk_q.seen && (trk_q.pend != '0);
        chg_code = trk_q.code;
        chg_amt  = trk_q.pend;
        if (clear || flush || done) begin
            trk_d.pend = '0;
            trk_d.seen = 1'b0;
            trk_d.code = '0;
        end else if (stall) begin
            if (!(&trk_q.pend)) begin
                trk_d.pend = trk_q.pend + 1'b1;
            end
            if (pick_any) begin
                trk_d.seen = 1'b1;
                trk_d.code = pick_code;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    AST_PEND_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (done || flush || clear) |=> (trk_q.pend == '0)); // R8

    AST_PEND_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        ((&trk_q.pend) && stall && !done && !flush && !clear) |=> (&trk_q.pend)); // R11

    AST_NO_CHARGE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_q.pend == '0) |-> !chg_vld); // R7

endmodule

// File: rtl/stall_cnt_bank.sv
module stall_cnt_bank #(
    parameter int NT = 2,
    parameter int NC = 6,
    parameter int CW = 3,
    parameter int TW = 1,
    parameter int DW = 32,
    parameter int PW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [NT-1:0]    chg_vld,
    input  logic [NT*CW-1:0] chg_code,
    input  logic [NT*PW-1:0] chg_amt,
    input  logic [TW-1:0]    rd_tid,
    input  logic [CW-1:0]    rd_sel,
    output logic [DW-1:0]    rd_data
);

    typedef struct packed {
        logic [NT-1:0][NC-1:0][DW-1:0] cnt;
        logic [DW-1:0]                 rd;
    } bank_t;

    bank_t bank_d, bank_q;

    function automatic logic [DW-1:0] sat_add(input logic [DW-1:0] a, input logic [PW-1:0] b);
        logic [DW:0] s;
        s = {1'b0, a} + (DW+1)'(b);
        return s[DW] ? '1 : s[DW-1:0];
    endfunction

    always_comb begin
        bank_d = bank_q;
        if ((int'(rd_tid) < NT) && (int'(rd_sel) < NC)) begin
            bank_d.rd = bank_q.cnt[rd_tid][rd_sel];
        end else begin
            bank_d.rd = '0;
        end
        for (int t = 0; t < NT; t++) begin
            for (int c = 0; c < NC; c++) begin
                if (chg_vld[t] && (chg_code[t*CW +: CW] == CW'(c))) begin
                    bank_d.cnt[t][c] = sat_add(bank_q.cnt[t][c], chg_amt[t*PW +: PW]);
                end
            end
        end
        if (clear) begin
            bank_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign rd_data = bank_q.rd;

    for (genvar gt = 0; gt < NT; gt++) begin : g_thr
        for (genvar gc = 0; gc < NC; gc++) begin : g_cause
            AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
                clear |=> (bank_q.cnt[gt][gc] == '0)); // R10

            AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
                !clear |=> (bank_q.cnt[gt][gc] >= $past(bank_q.cnt[gt][gc]))); // R11
        end
    end

endmodule

// File: rtl/stall_attrib_ctr.sv
module stall_attrib_ctr #(
    parameter  int NUM_THR = 2,
    parameter  int CNT_W   = 32,
    localparam int NC      = stall_attrib_pkg::CAUSE_N,
    localparam int TID_W   = (NUM_THR > 1) ? $clog2(NUM_THR) : 1,
    localparam int SEL_W   = $clog2(NC)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic [NUM_THR-1:0]    grp_stall,
    input  logic [NUM_THR*NC-1:0] stall_why,
    input  logic [NUM_THR-1:0]    grp_done,
    input  logic [NUM_THR-1:0]    grp_flush,
    input  logic [TID_W-1:0]      rd_tid,
    input  logic [SEL_W-1:0]      rd_sel,
    output logic [CNT_W-1:0]      rd_data
);

    localparam int PEND_W = CNT_W;

    logic [NUM_THR-1:0]        chg_vld;
    logic [NUM_THR*SEL_W-1:0]  chg_code;
    logic [NUM_THR*PEND_W-1:0] chg_amt;

    for (genvar t = 0; t < NUM_THR; t++) begin : g_trk
        stall_thread_track #(.NC(NC), .CW(SEL_W), .PW(PEND_W)) u_trk (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (clear),
            .stall    (grp_stall[t]),
            .why      (stall_why[t*NC +: NC]),
            .done     (grp_done[t]),
            .flush    (grp_flush[t]),
            .chg_vld  (chg_vld[t]),
            .chg_code (chg_code[t*SEL_W +: SEL_W]),
            .chg_amt  (chg_amt[t*PEND_W +: PEND_W])
        );

        AST_FLUSH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
            grp_flush[t] |-> !chg_vld[t]); // R6

        AST_CHARGE_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
            chg_vld[t] |-> grp_done[t]); // R2
    end

    stall_cnt_bank #(
        .NT (NUM_THR), .NC (NC), .CW (SEL_W), .TW (TID_W), .DW (CNT_W), .PW (PEND_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .chg_vld  (chg_vld),
        .chg_code (chg_code),
        .chg_amt  (chg_amt),
        .rd_tid   (rd_tid),
        .rd_sel   (rd_sel),
        .rd_data  (rd_data)
    );

    AST_CLEAR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        clear |-> (chg_vld == '0)); // R10

endmodule

// File: tb/stall_attrib_ctr_tb.sv
module stall_attrib_ctr_tb;
    import stall_attrib_pkg::*;

    localparam int CYC = 20;
    localparam int W   = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clear = 1'b0;
    logic [1:0]   grp_stall = '0;
    logic [11:0]  stall_why = '0;
    logic [1:0]   grp_done = '0;
    logic [1:0]   grp_flush = '0;
    logic [0:0]   rd_tid = '0;
    logic [2:0]   rd_sel = '0;
    logic [W-1:0] rd_data;

    logic rd_fire = 1'b0;
    int   checks = 0;
    int   fails  = 0;
    logic [W-1:0] exp_q[$];
    string        tag_q[$];

    always #(CYC/2) clk = ~clk;

    stall_attrib_ctr #(.NUM_THR(2), .CNT_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .clear(clear), .grp_stall(grp_stall),
        .stall_why(stall_why), .grp_done(grp_done), .grp_flush(grp_flush),
        .rd_tid(rd_tid), .rd_sel(rd_sel), .rd_data(rd_data)
    );

    // monitor: pops one expected item per read and compares
    always @(posedge clk) begin
        if (rd_fire) begin
            #5;
            if (exp_q.size() != 0) begin
                logic [W-1:0] e;
                string tg;
                e  = exp_q.pop_front();
                tg = tag_q.pop_front();
                checks++;
                if (rd_data !== e) begin
                    fails++;
                    $display("FAIL %s: got %0d expected %0d", tg, rd_data, e);
                end
            end
        end
    end

    function automatic logic [11:0] wh(input int t, input logic [5:0] m);
        return (t == 0) ? {6'b0, m} : {m, 6'b0};
    endfunction

    task automatic step(input logic [1:0] st, input logic [11:0] wy,
                        input logic [1:0] dn, input logic [1:0] fl, input logic cl);
        grp_stall = st; stall_why = wy; grp_done = dn; grp_flush = fl; clear = cl;
        @(negedge clk);
        rd_fire = 1'b0;
        grp_stall = '0; stall_why = '0; grp_done = '0; grp_flush = '0; clear = 1'b0;
    endtask

    task automatic arm(input int t, input int c, input logic [W-1:0] e, input string tg);
        rd_tid = 1'(t); rd_sel = 3'(c); rd_fire = 1'b1;
        exp_q.push_back(e); tag_q.push_back(tg);
    endtask

    task automatic rd(input int t, input int c, input logic [W-1:0] e, input string tg);
        arm(t, c, e, tg);
        step(2'b00, '0, 2'b00, 2'b00, 1'b0);
    endtask

    task automatic stall_n(input int t, input logic [5:0] m, input int n);
        for (int i = 0; i < n; i++) begin
            step(2'(1 << t), wh(t, m), 2'b00, 2'b00, 1'b0);
        end
    endtask

    task automatic finish_t(input int t);
        step(2'b00, '0, 2'(1 << t), 2'b00, 1'b0);
    endtask

    initial begin
        #(CYC * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog: got hung expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (rd_data !== '0) begin
            fails++;
            $display("FAIL R1 reset rd_data: got %0d expected 0", rd_data);
        end
        rst_n = 1'b1;
        @(negedge clk);
        rd(0, CZ_MISS, 8'd0, "R1 reset t0 miss");
        rd(1, CZ_BRFLUSH, 8'd0, "R1 reset t1 brflush");

        // R2: three fp stall cycles then completion
        stall_n(0, 6'b001000, 3);
        finish_t(0);
        rd(0, CZ_FPOP, 8'd3, "R2 lump charge fp");

        // R3: fx, then idiv, then stalled cycle with no cause
        stall_n(0, 6'b010000, 1);
        stall_n(0, 6'b000100, 1);
        stall_n(0, 6'b000000, 1);
        finish_t(0);
        rd(0, CZ_IDIV, 8'd3, "R3 latest cause idiv");
        rd(0, CZ_FXOP, 8'd0, "R3 earlier cause fx not charged");

        // R4: same-cycle priority
        stall_n(0, 6'b011010, 1);
        finish_t(0);
        rd(0, CZ_DSQRT, 8'd1, "R4 dsqrt over fp/fx");
        stall_n(0, 6'b100001, 2);
        finish_t(0);
        rd(0, CZ_MISS, 8'd2, "R4 miss over brflush");
        rd(0, CZ_BRFLUSH, 8'd0, "R4 brflush lost");

        // R5: both threads together
        step(2'b11, wh(0, 6'b010000) | wh(1, 6'b100000), 2'b00, 2'b00, 1'b0);
        step(2'b11, wh(0, 6'b010000) | wh(1, 6'b100000), 2'b00, 2'b00, 1'b0);
        stall_n(1, 6'b100000, 2);
        step(2'b00, '0, 2'b11, 2'b00, 1'b0);
        rd(1, CZ_BRFLUSH, 8'd4, "R5 t1 brflush");
        rd(0, CZ_FXOP, 8'd2, "R5 t0 fx");
        rd(1, CZ_FXOP, 8'd0, "R5 t1 fx untouched");

        // R6: flush discards; flush with done discards
        stall_n(0, 6'b000001, 5);
        step(2'b00, '0, 2'b00, 2'b01, 1'b0);
        finish_t(0);
        rd(0, CZ_MISS, 8'd2, "R6 flush discards");
        stall_n(0, 6'b000001, 2);
        step(2'b00, '0, 2'b01, 2'b01, 1'b0);
        rd(0, CZ_MISS, 8'd2, "R6 flush with done discards");

        // R7: no-cause stall is dropped
        finish_t(0);
        stall_n(0, 6'b000000, 3);
        finish_t(0);
        rd(0, CZ_BRFLUSH, 8'd0, "R7 no cause brflush");
        rd(0, CZ_FPOP, 8'd3, "R7 no cause fp unchanged");

        // R8: completion-cycle flags ignored, restart next cycle
        stall_n(0, 6'b001000, 2);
        step(2'b01, wh(0, 6'b000001), 2'b01, 2'b00, 1'b0);
        stall_n(0, 6'b010000, 1);
        finish_t(0);
        rd(0, CZ_FPOP, 8'd5, "R8 fp charged");
        rd(0, CZ_MISS, 8'd2, "R8 done-cycle miss ignored");
        rd(0, CZ_FXOP, 8'd3, "R8 restart next cycle");

        // R9: read in the same cycle as a charge to the same counter
        stall_n(1, 6'b100000, 2);
        arm(1, CZ_BRFLUSH, 8'd4, "R9 same-cycle read sees old");
        step(2'b00, '0, 2'b10, 2'b00, 1'b0);
        rd(1, CZ_BRFLUSH, 8'd6, "R9 next read sees new");
        rd(1, 7, 8'd0, "R9 sel 7 zero");
        rd(0, 6, 8'd0, "R9 sel 6 zero");

        // R11: saturation of counter and pending
        stall_n(1, 6'b000100, 250);
        finish_t(1);
        rd(1, CZ_IDIV, 8'd250, "R11 count 250");
        stall_n(1, 6'b000100, 10);
        finish_t(1);
        rd(1, CZ_IDIV, 8'd255, "R11 counter saturates");
        stall_n(1, 6'b001000, 300);
        finish_t(1);
        rd(1, CZ_FPOP, 8'd255, "R11 pending saturates");

        // R10: clear beats completion; clear drops pending
        stall_n(0, 6'b010000, 3);
        step(2'b00, '0, 2'b01, 2'b00, 1'b1);
        rd(0, CZ_FXOP, 8'd0, "R10 clear beats done");
        rd(1, CZ_IDIV, 8'd0, "R10 clear t1 idiv");
        rd(1, CZ_FPOP, 8'd0, "R10 clear t1 fp");
        stall_n(0, 6'b000001, 2);
        step(2'b00, '0, 2'b00, 2'b00, 1'b1);
        stall_n(0, 6'b010000, 1);
        finish_t(0);
        rd(0, CZ_FXOP, 8'd1, "R10 post-clear fx");
        rd(0, CZ_MISS, 8'd0, "R10 pending cleared");

        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule